// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit ports, called A and B, and can pass data across in either direction. Each direction has its own storage register with its own clock and its own synchronous reset. The register for the A-to-B direction samples the A input. The register for the B-to-A direction samples the B input. Loading is never blocked by the enable or direction controls, so either register can take in data at any time, even while both ports are undriven.

An active-low output enable and a direction input decide which port is driven, if any. When a port is driven, a per-direction select chooses its source. The source is either the live value on the opposite port, passed through combinational logic, or the contents of the register for that direction.

Each bidirectional port is modelled as three vectors: an input, an output and an output enable. The driven port's output-enable vector is all ones, and the undriven port's output and output-enable vectors are all zeros.

Top module: `bus_xcvr_reg`

## Requirements
- R1: Both data paths are W bits wide (default 8). Each port's output-enable vector is W bits wide, and all its bits are either 1 or 0 together.
- R2: On a rising edge of `clk_ab`, the A-to-B register loads `a_in`. If `rst_ab` is high at that edge, it loads zero instead.
- R3: On a rising edge of `clk_ba`, the B-to-A register loads `b_in`. If `rst_ba` is high at that edge, it loads zero instead.
- R4: Register loading does not depend on `oe_n` or `dir`. Data loaded while `oe_n`=1 can be read out later in stored mode.
- R5: While `oe_n`=1, `a_oe`, `b_oe`, `a_out` and `b_out` are all zero.
- R6: While `oe_n`=0 and `dir`=1, `b_oe` is all ones and `a_oe` is zero. `b_out` equals the A-to-B register when `sel_ab`=1, and equals `a_in` when `sel_ab`=0.
- R7: While `oe_n`=0 and `dir`=0, `a_oe` is all ones and `b_oe` is zero. `a_out` equals the B-to-A register when `sel_ba`=1, and equals `b_in` when `sel_ba`=0.
- R8: `a_oe` and `b_oe` are never both nonzero.
- R9: The select of the direction that is not driving has no effect on any output.
- R10: A stored value does not change when `oe_n`, `dir`, the selects or the port inputs change. It changes only at the next rising edge of its own clock.
- R11: In real-time mode, the driven output follows the opposite port's input in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Load clock for the A-to-B register |
| rst_ab | input | 1 | Synchronous active-high clear for the A-to-B register |
| clk_ba | input | 1 | Load clock for the B-to-A register |
| rst_ba | input | 1 | Synchronous active-high clear for the B-to-A register |
| oe_n | input | 1 | Active-low output enable. When 1, neither port is driven |
| dir | input | 1 | 1 drives port B from the A side; 0 drives port A from the B side |
| sel_ab | input | 1 | Source for the B output: 1 selects stored data, 0 selects live data |
| sel_ba | input | 1 | Source for the A output: 1 selects stored data, 0 selects live data |
| a_in | input | W | Value present on port A |
| a_out | output | W | Value driven onto port A |
| a_oe | output | W | Per-bit drive enable for port A |
| b_in | input | W | Value present on port B |
| b_out | output | W | Value driven onto port B |
| b_oe | output | W | Per-bit drive enable for port B |

## Verification
The bench runs all sixteen combinations of `oe_n`, `dir`, `sel_ab` and `sel_ba` against several pairs of A and B data patterns. Choosing different values for the live inputs and the stored contents means each output value points to only one source. A wrong select, the wrong direction or a missing gate therefore gives an observable mismatch.

Separate steps check the following:
- Loading while isolated.
- Toggling only the inactive select.
- Changing the live inputs without a clock edge.
- Clocking one register while the other is held.

These steps separate true loading from combinational leakage and confirm that the stored values persist.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  src_sel_e     sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      SRC_STORED: y = stored;
      default:    y = live;
    endcase
  end
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl (
  input  logic oe_n,
  input  logic dir,
  output logic drv_a,
  output logic drv_b
);
  always_comb begin
    drv_a = 1'b0;
    drv_b = 1'b0;
    if (!oe_n) begin
      if (dir) drv_b = 1'b1;
      else     drv_a = 1'b1;
    end
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_ab,
  input  logic         rst_ab,
  input  logic         clk_ba,
  input  logic         rst_ba,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic [W-1:0] q_ab, q_ba;
  logic [W-1:0] to_b, to_a;
  logic         drv_a, drv_b;

  // R2, R3: one register per direction, each in its own clock domain
  xcvr_capture_reg #(.W(W)) u_reg_ab (.clk(clk_ab), .rst(rst_ab), .d(a_in), .q(q_ab));
  xcvr_capture_reg #(.W(W)) u_reg_ba (.clk(clk_ba), .rst(rst_ba), .d(b_in), .q(q_ba));

  xcvr_path_mux #(.W(W)) u_mux_ab (
    .sel(src_sel_e'(sel_ab)), .live(a_in), .stored(q_ab), .y(to_b));
  xcvr_path_mux #(.W(W)) u_mux_ba (
    .sel(src_sel_e'(sel_ba)), .live(b_in), .stored(q_ba), .y(to_a));

  xcvr_drive_ctrl u_ctrl (.oe_n(oe_n), .dir(dir), .drv_a(drv_a), .drv_b(drv_b));

  // Per-bit output gating
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign a_oe[i]  = drv_a;
    assign b_oe[i]  = drv_b;
    assign a_out[i] = drv_a & to_a[i];
    assign b_out[i] = drv_b & to_b[i];
  end
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_ab,
  input logic         rst_ab,
  input logic         clk_ba,
  input logic         rst_ba,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] q_ab,
  input logic [W-1:0] q_ba
);
  a_r2_load_ab: assert property (@(posedge clk_ab) disable iff (rst_ab)
    1'b1 |=> (q_ab == $past(a_in)));
  a_r2_clear_ab: assert property (@(posedge clk_ab) rst_ab |=> (q_ab == '0));
  a_r3_load_ba: assert property (@(posedge clk_ba) disable iff (rst_ba)
    1'b1 |=> (q_ba == $past(b_in)));
  a_r3_clear_ba: assert property (@(posedge clk_ba) rst_ba |=> (q_ba == '0));

  always_comb begin
    a_r8_one_side: assert (!((|a_oe) && (|b_oe)));
    a_r1_oe_uniform: assert ((a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1));
    if (oe_n) begin
      a_r5_isolated: assert (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0);
    end
    if (!oe_n && dir) begin
      a_r6_drive_b: assert (b_oe == '1 && b_out == (sel_ab ? q_ab : a_in));
    end
    if (!oe_n && !dir) begin
      a_r7_drive_a: assert (a_oe == '1 && a_out == (sel_ba ? q_ba : b_in));
    end
  end
endmodule

bind bus_xcvr_reg xcvr_checker #(.W(W)) u_chk (.*);

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int unsigned W = 8;

  logic clk_ab = 0, clk_ba = 0, rst_ab = 1, rst_ba = 1;
  logic oe_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [W-1:0] ref_ab = '0, ref_ba = '0;
  int errs = 0, checks = 0;
  bit done = 0;

  bus_xcvr_reg #(.W(W)) dut (.*);

  // 250 MHz: each pulse is a 4 ns clock period
  task automatic pulse_ab();
    #1 clk_ab = 1;
    ref_ab = rst_ab ? '0 : a_in;
    #2 clk_ab = 0;
    #1;
  endtask

  task automatic pulse_ba();
    #1 clk_ba = 1;
    ref_ba = rst_ba ? '0 : b_in;
    #2 clk_ba = 0;
    #1;
  endtask

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Full expected output computed from the requirements
  task automatic check_all(string tag);
    logic [W-1:0] ea_out, ea_oe, eb_out, eb_oe;
    #1;
    ea_out = '0; ea_oe = '0; eb_out = '0; eb_oe = '0;
    if (!oe_n && dir) begin
      eb_oe = '1; eb_out = sel_ab ? ref_ab : a_in;
    end else if (!oe_n) begin
      ea_oe = '1; ea_out = sel_ba ? ref_ba : b_in;
    end
    cmp(tag, "a_out", a_out, ea_out);
    cmp(tag, "a_oe", a_oe, ea_oe);
    cmp(tag, "b_out", b_out, eb_out);
    cmp(tag, "b_oe", b_oe, eb_oe);
    cmp("R8", "both_oe", {{(W-1){1'b0}}, (|a_oe) & (|b_oe)}, '0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] snap;
    // Reset: both registers clear
    a_in = 8'hFF; b_in = 8'hFF;
    pulse_ab(); pulse_ba();
    rst_ab = 0; rst_ba = 0;
    oe_n = 0; dir = 1; sel_ab = 1; check_all("R2");
    dir = 0; sel_ba = 1; check_all("R3");
    oe_n = 1; check_all("R5");

    // R4: load while isolated
    a_in = 8'hA5; b_in = 8'h3C; dir = 1;
    pulse_ab(); pulse_ba();
    check_all("R5");
    a_in = 8'h00; b_in = 8'h00;
    oe_n = 0; dir = 1; sel_ab = 1; check_all("R4");
    cmp("R4", "stored_ab", b_out, 8'hA5);
    dir = 0; sel_ba = 1; check_all("R4");
    cmp("R4", "stored_ba", a_out, 8'h3C);

    // Sweep: data patterns x all control combinations
    for (int p = 0; p < 8; p++) begin
      a_in = W'(p * 37 + 5); b_in = W'(~(p * 53 + 11));
      if (p[0]) pulse_ab(); else pulse_ba();
      a_in = W'(p * 91 + 70); b_in = W'(p * 29 + 200);
      for (int c = 0; c < 16; c++) begin
        {oe_n, dir, sel_ab, sel_ba} = 4'(c);
        check_all(oe_n ? "R5" : (dir ? "R6" : "R7"));
      end
    end

    // R9: toggling the inactive select changes nothing
    oe_n = 0; dir = 1; sel_ab = 0; sel_ba = 0; a_in = 8'h5A; b_in = 8'hC3;
    #1 snap = b_out;
    sel_ba = 1; #1 cmp("R9", "b_out", b_out, snap); check_all("R9");
    dir = 0; sel_ba = 1; #1 snap = a_out;
    sel_ab = 1; #1 cmp("R9", "a_out", a_out, snap);
    sel_ab = 0; #1 cmp("R9", "a_out", a_out, snap); check_all("R9");

    // R11: live path follows input without a clock
    dir = 1; sel_ab = 0;
    for (int v = 0; v < 256; v += 17) begin
      a_in = W'(v); check_all("R11");
      cmp("R11", "live_b", b_out, W'(v));
    end

    // R10: stored data persists across control and input changes
    a_in = 8'h96; pulse_ab();
    b_in = 8'h69; pulse_ba();
    for (int c = 0; c < 16; c++) begin
      {oe_n, dir, sel_ab, sel_ba} = 4'(c);
      a_in = W'(c * 13); b_in = W'(c * 7 + 1);
      #2;
    end
    oe_n = 0; dir = 1; sel_ab = 1; check_all("R10");
    cmp("R10", "hold_ab", b_out, 8'h96);
    dir = 0; sel_ba = 1; check_all("R10");
    cmp("R10", "hold_ba", a_out, 8'h69);
    // Clocking one register leaves the other alone
    b_in = 8'h11; a_in = 8'h22; pulse_ab();
    check_all("R10");
    cmp("R10", "ba_untouched", a_out, 8'h69);
    pulse_ba(); check_all("R3");
    cmp("R3", "ba_new", a_out, 8'h11);

    // Reset again mid-run
    rst_ab = 1; pulse_ab(); rst_ab = 0;
    dir = 1; check_all("R2");
    cmp("R2", "cleared", b_out, '0);
    cmp("R1", "oe_all", b_oe, {W{1'b1}});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule